// File: doc/BRIEF.md
# Element Width Cast Unit

This block takes one vector register image laid out in the chunk-interleaved register format at one element width and rewrites it as the register image the same bytes would have at another element width. The register is split into datapath chunks of `SLEN` bits. At a given element width, elements are dealt to the chunks round-robin, so consecutive elements in memory order sit in neighbouring chunks rather than next to each other. A cast therefore cannot simply relabel the bits. It has to move bytes across chunk boundaries so that the result is exactly what a store at the old width followed by a load at the new width would leave in the register.

The unit first undoes the source-width interleave to recover the memory-order byte string. It then deals that string out again at the destination width. Software issues a one-cycle `start` with the two width codes and the register image. One cycle later the recast image appears on `reg_out` together with a one-cycle `done` pulse. When the chunk width equals the register width, every cast reduces to a copy.

Top module: `ewcast_unit`

## Requirements
- R1: While `rst_n` is low, `done`, `err` and `reg_out` are all zero.
- R2: Width codes are 0 = 8 bits, 1 = 16 bits, 2 = 32 bits and 3 = 64 bits. At width code w, with NCH = VLEN/SLEN chunks, element i in memory order sits in chunk (i mod NCH), in slot floor(i/NCH) of that chunk, with its bytes little-endian (lowest memory byte in the least significant byte). The output is the image at `dst_w` of the memory bytes that `reg_in` holds at `src_w`.
- R3: For an 8-bit to 16-bit cast, output element j is the memory bytes 2j (low half) and 2j+1 (high half) joined.
- R4: When `src_w` equals `dst_w` and both are legal, `reg_out` equals `reg_in`.
- R5: Casting from width A to width B and then from B back to A returns the original image.
- R6: When SLEN equals VLEN, every legal cast returns `reg_in` unchanged.
- R7: An accepted `start` gives `done` high for exactly the next cycle. `reg_out` and `err` change only in that cycle and hold their values otherwise.
- R8: A `start` seen while `done` is high is ignored: no second pulse is produced, and the output keeps the earlier result.
- R9: If either width code names a width wider than SLEN, `err` is 1 for that result and `reg_out` equals `reg_in`. Otherwise `err` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Request a cast this cycle |
| src_w | input | 2 | Element width code of `reg_in` |
| dst_w | input | 2 | Element width code wanted on `reg_out` |
| reg_in | input | VLEN | Register image at the source width |
| reg_out | output | VLEN | Recast register image |
| done | output | 1 | One-cycle pulse marking a new result |
| err | output | 1 | Illegal width seen; result is a pass-through |

## Verification
The assertions check several properties on every cycle. The shape of the `done` pulse is checked, as is the refusal of a start that arrives while `done` is high. The output must hold between results. The error pass-through, the equal-width identity and the flat-chunk copy are each checked against the input sampled a cycle earlier. Only the bench's scenarios can show that the byte permutation itself is right. It does this in three ways: a reference model compares the outputs of a chunked and a flat instance every clock, a directed 8-to-16 pattern checks the byte concatenation, and round trips for every legal width pair must return the original image.

// File: rtl/ewcast_pkg.sv
package ewcast_pkg;

  // bytes in one element for a width code
  function automatic int elem_bytes(input int code);
    return 1 << code;
  endfunction

  // a width is usable only if one element fits inside a chunk
  function automatic bit code_fits(input int code, input int slen);
    return (8 << code) <= slen;
  endfunction

  // register byte index holding memory byte mb at width code
  function automatic int reg_byte_of(input int mb, input int code,
                                     input int vlen, input int slen);
    int eb, nch, cb, e, k;
    eb  = elem_bytes(code);
    nch = vlen / slen;
    cb  = slen / 8;
    e   = mb / eb;
    k   = mb % eb;
    return (e % nch) * cb + (e / nch) * eb + k;
  endfunction

endpackage

// File: rtl/ewcast_gather.sv
// Undo the round-robin interleave: register format -> memory byte order.
module ewcast_gather #(
  parameter int VLEN = 128,
  parameter int SLEN = 32
) (
  input  logic [VLEN-1:0] reg_in,
  input  logic [1:0]      wcode,
  output logic [VLEN-1:0] mem_out
);
  localparam int NB = VLEN / 8;

  logic [3:0][VLEN-1:0] img;

  for (genvar w = 0; w < 4; w++) begin : g_w
    if (ewcast_pkg::code_fits(w, SLEN)) begin : g_ok
      for (genvar b = 0; b < NB; b++) begin : g_b
        localparam int P = ewcast_pkg::reg_byte_of(b, w, VLEN, SLEN);
        assign img[w][8*b +: 8] = reg_in[8*P +: 8];
      end
    end else begin : g_na
      assign img[w] = reg_in;
    end
  end

  always_comb mem_out = img[wcode];
endmodule

// File: rtl/ewcast_scatter.sv
// Deal memory-order bytes round-robin into chunks at the destination width.
module ewcast_scatter #(
  parameter int VLEN = 128,
  parameter int SLEN = 32
) (
  input  logic [VLEN-1:0] mem_in,
  input  logic [1:0]      wcode,
  output logic [VLEN-1:0] reg_out
);
  localparam int NB = VLEN / 8;

  logic [3:0][VLEN-1:0] img;

  for (genvar w = 0; w < 4; w++) begin : g_w
    if (ewcast_pkg::code_fits(w, SLEN)) begin : g_ok
      for (genvar b = 0; b < NB; b++) begin : g_b
        localparam int P = ewcast_pkg::reg_byte_of(b, w, VLEN, SLEN);
        assign img[w][8*P +: 8] = mem_in[8*b +: 8];
      end
    end else begin : g_na
      assign img[w] = mem_in;
    end
  end

  always_comb reg_out = img[wcode];
endmodule

// File: rtl/ewcast_ctrl.sv
// Start acceptance, result register and done pulse.
module ewcast_ctrl #(
  parameter int VLEN = 128
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic            width_bad,
  input  logic [VLEN-1:0] cast_img,
  input  logic [VLEN-1:0] raw_img,
  output logic [VLEN-1:0] reg_out,
  output logic            done,
  output logic            err
);
  logic cast_accept;

  assign cast_accept = start & ~done;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      reg_out <= '0;
      done    <= 1'b0;
      err     <= 1'b0;
    end else begin
      done <= cast_accept;
      if (cast_accept) begin
        reg_out <= width_bad ? raw_img : cast_img;
        err     <= width_bad;
      end
    end
  end

  assert_done_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_done_after_start_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(start));

  assert_hold_between_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> ($stable(reg_out) && $stable(err)));

  assert_busy_start_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (start && done) |=> (!done && $stable(reg_out)));

  assert_bad_passthru_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (done && err) |-> (reg_out == $past(raw_img)));
endmodule

// File: rtl/ewcast_unit.sv
module ewcast_unit #(
  parameter int VLEN = 128,
  parameter int SLEN = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic [1:0]      src_w,
  input  logic [1:0]      dst_w,
  input  logic [VLEN-1:0] reg_in,
  output logic [VLEN-1:0] reg_out,
  output logic            done,
  output logic            err
);
  localparam int NCH = VLEN / SLEN;

  logic [VLEN-1:0] mem_order;
  logic [VLEN-1:0] recast;
  logic            width_bad;

  always_comb
    width_bad = !ewcast_pkg::code_fits(int'(src_w), SLEN) ||
                !ewcast_pkg::code_fits(int'(dst_w), SLEN);

  ewcast_gather #(.VLEN(VLEN), .SLEN(SLEN)) u_gather (
    .reg_in (reg_in),
    .wcode  (src_w),
    .mem_out(mem_order)
  );

  ewcast_scatter #(.VLEN(VLEN), .SLEN(SLEN)) u_scatter (
    .mem_in (mem_order),
    .wcode  (dst_w),
    .reg_out(recast)
  );

  ewcast_ctrl #(.VLEN(VLEN)) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .width_bad(width_bad),
    .cast_img (recast),
    .raw_img  (reg_in),
    .reg_out  (reg_out),
    .done     (done),
    .err      (err)
  );

  assert_same_width_identity_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !err && $past(src_w == dst_w)) |-> (reg_out == $past(reg_in)));

  assert_flat_copy_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (NCH == 1 && done && !err) |-> (reg_out == $past(reg_in)));

  assert_err_matches_width_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (err == $past(width_bad)));
endmodule

// File: tb/ewcast_unit_test.sv
module ewcast_unit_test;
  localparam int VLEN = 128;
  localparam int SLEN = 32;
  localparam int NB   = VLEN / 8;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            start = 1'b0;
  logic [1:0]      src_w = '0;
  logic [1:0]      dst_w = '0;
  logic [VLEN-1:0] reg_in = '0;
  logic [VLEN-1:0] reg_out, f_out;
  logic            done, err, f_done, f_err;

  int vectors = 0;
  int miscompares = 0;
  int cyc = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  ewcast_unit #(.VLEN(VLEN), .SLEN(SLEN)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .src_w(src_w), .dst_w(dst_w),
    .reg_in(reg_in), .reg_out(reg_out), .done(done), .err(err));

  ewcast_unit #(.VLEN(VLEN), .SLEN(VLEN)) uut_flat (
    .clk(clk), .rst_n(rst_n), .start(start), .src_w(src_w), .dst_w(dst_w),
    .reg_in(reg_in), .reg_out(f_out), .done(f_done), .err(f_err));

  // reference: walk chunks and slots, store to a byte list, reload
  function automatic logic [VLEN-1:0] ref_cast(input logic [VLEN-1:0] r,
      input int s, input int d, input int slen);
    logic [7:0] mem [NB];
    logic [VLEN-1:0] o;
    int nch, sb, db, cb;
    if ((8 << s) > slen || (8 << d) > slen) return r;
    nch = VLEN / slen; cb = slen / 8; sb = 1 << s; db = 1 << d;
    for (int c = 0; c < nch; c++)
      for (int t = 0; t < cb / sb; t++)
        for (int k = 0; k < sb; k++)
          mem[(t * nch + c) * sb + k] = r[8 * (c * cb + t * sb + k) +: 8];
    o = '0;
    for (int c = 0; c < nch; c++)
      for (int t = 0; t < cb / db; t++)
        for (int k = 0; k < db; k++)
          o[8 * (c * cb + t * db + k) +: 8] = mem[(t * nch + c) * db + k];
    return o;
  endfunction

  function automatic bit ref_bad(input int s, input int d, input int slen);
    return ((8 << s) > slen) || ((8 << d) > slen);
  endfunction

  logic [VLEN-1:0] e_out, ef_out;
  logic            e_done, e_err, ef_err;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      e_out <= '0; ef_out <= '0; e_done <= 1'b0; e_err <= 1'b0; ef_err <= 1'b0;
    end else if (start && !e_done) begin
      e_done <= 1'b1;
      e_out  <= ref_cast(reg_in, int'(src_w), int'(dst_w), SLEN);
      e_err  <= ref_bad(int'(src_w), int'(dst_w), SLEN);
      ef_out <= ref_cast(reg_in, int'(src_w), int'(dst_w), VLEN);
      ef_err <= ref_bad(int'(src_w), int'(dst_w), VLEN);
    end else begin
      e_done <= 1'b0;
    end
  end

  task automatic chk(input string tag, input logic [VLEN-1:0] act,
                     input logic [VLEN-1:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // every-cycle comparison against the model (R2 permutation, R7 timing, R9 flag, R6 flat)
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      chk("R2 chunked reg_out", reg_out, e_out);
      chk("R7 done", {{(VLEN-1){1'b0}}, done}, {{(VLEN-1){1'b0}}, e_done});
      chk("R9 err", {{(VLEN-1){1'b0}}, err}, {{(VLEN-1){1'b0}}, e_err});
      chk("R6 flat reg_out", f_out, ef_out);
      chk("R6 flat err", {{(VLEN-1){1'b0}}, f_err}, {{(VLEN-1){1'b0}}, ef_err});
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000 && !finished) begin
      finished = 1;
      miscompares++;
      $display("FAIL watchdog act=%0d cycles exp=done", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  task automatic do_op(input int s, input int d, input logic [VLEN-1:0] v);
    @(negedge clk);
    src_w = 2'(s); dst_w = 2'(d); reg_in = v; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  function automatic logic [VLEN-1:0] rnd_vec();
    logic [VLEN-1:0] v;
    for (int i = 0; i < VLEN / 32; i++) v[32*i +: 32] = $urandom;
    return v;
  endfunction

  initial begin
    logic [VLEN-1:0] x, y, pat, held;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 reg_out in reset", reg_out, '0);
    chk("R1 done/err in reset", {{(VLEN-2){1'b0}}, done, err}, '0);
    rst_n = 1'b1;
    @(negedge clk);

    // R2 R9 R6: every width pair, several data patterns
    for (int rep = 0; rep < 6; rep++)
      for (int s = 0; s < 4; s++)
        for (int d = 0; d < 4; d++) begin
          x = (rep == 0) ? {NB{8'hA5}} : rnd_vec();
          do_op(s, d, x);
          if (s == d && s < 3) chk("R4 identity", reg_out, x);
          if (s == 3 || d == 3) chk("R9 passthru", reg_out, x);
          chk("R6 flat copy", f_out, x);
          @(negedge clk);
        end

    // R3 8->16 concatenation: memory byte b holds value b
    pat = '0;
    for (int b = 0; b < NB; b++) pat[8 * ((b % 4) * 4 + b / 4) +: 8] = 8'(b);
    do_op(0, 1, pat);
    for (int j = 0; j < NB / 2; j++)
      chk("R3 halfword", {{(VLEN-16){1'b0}}, reg_out[8 * ((j % 4) * 4 + (j / 4) * 2) +: 16]},
          {{(VLEN-16){1'b0}}, 8'(2*j+1), 8'(2*j)});

    // R5 round trips
    for (int s = 0; s < 3; s++)
      for (int d = 0; d < 3; d++) begin
        x = rnd_vec();
        do_op(s, d, x);
        y = reg_out;
        do_op(d, s, y);
        chk("R5 round trip", reg_out, x);
      end

    // R8 start held two cycles, data changed in the second
    x = rnd_vec();
    @(negedge clk);
    src_w = 2'd0; dst_w = 2'd2; reg_in = x; start = 1'b1;
    @(negedge clk);
    held = reg_out;
    reg_in = ~x; src_w = 2'd1;
    @(negedge clk);
    start = 1'b0;
    chk("R8 ignored start keeps result", reg_out, held);
    chk("R8 no second pulse", {{(VLEN-1){1'b0}}, done}, '0);

    // R7 idle cycles with moving inputs: output holds
    held = reg_out;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      reg_in = rnd_vec(); src_w = 2'(i);
    end
    chk("R7 hold while idle", reg_out, held);

    @(negedge clk);
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule